// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer placed on a simple register bus. It has three 16-bit registers: a control word, a reload value and a live down-counter. The peripheral clock first goes through an 8-bit programmable prescaler. A second divider then divides it further by 16, 32, 64 or 128. Each pulse from this two-stage chain lowers the live count by one while counting is enabled.

When the count runs out, the control word sets what happens. If the reset action is selected, the block raises a system reset request and holds it. If it is not, the block reloads the count from the reload register, keeps counting, and can send a one-cycle interrupt. Software keeps the system alive by rewriting the live count before it expires. Reads of the count return its current value.

Top module: `wdt_timer`

## Requirements
- R1: Registers are decoded from the byte offset `addr`: control at 0x0, reload at 0x4, live count at 0x8. Any other offset reads as zero, and writes to it change no register.
- R2: After a synchronous reset, control reads 0x8021 and both reload and count read 0x8000. `irq` and `reset_req` are low.
- R3: Control bits 15:8 hold a prescale value P and bits 4:3 a selector S. While enabled, the count drops by one every (P+1)·2^(S+4) clocks, counted from the write that last restarted the chain.
- R4: When control bit 5 is clear, the live count holds its value.
- R5: On expiry with control bit 0 set, `reset_req` rises and stays high until reset. The count stops at zero and nothing is reloaded.
- R6: On expiry with control bit 0 clear, the count reloads from the reload register. `irq` is high for exactly one cycle only if control bit 2 is set.
- R7: A write to the live count loads it at once and restarts the division chain. A write to the reload register leaves the live count unchanged.
- R8: Expiry occurs on a divided pulse when the count is 1, or when it is already 0. The count never wraps below zero.
- R9: A write to control restarts the division chain, so the next decrement comes one full period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | One-cycle interrupt pulse per expiry |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The assertions assume that software never rewrites control on the same clock edge as an expiry. They also assume no count write lands while `reset_req` is already set. Under either event the reload and hold properties would compare against a value that changed on that edge. The stimulus keeps to this rule by writing each register on its own edge. It also places every write well away from computed expiry edges and stops writing the count once a reset request has been raised. Prescale values and counts are drawn in small ranges so that each random expiry is reached within a few thousand cycles.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    localparam int REG_W        = 16;
    localparam int ADDR_W       = 4;
    localparam int PRE_W        = 8;
    localparam int SEL_W        = 2;
    localparam int DIV_BASE_LOG = 4;
    localparam int SEL_MAX      = (1 << SEL_W) - 1;
    localparam int DIV_W        = DIV_BASE_LOG + SEL_MAX;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_RELD = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h8;

    localparam logic [REG_W-1:0] CTRL_INIT = 16'h8021;
    localparam logic [REG_W-1:0] RELD_INIT = 16'h8000;
    localparam logic [REG_W-1:0] CNT_INIT  = 16'h8000;

    // control word layout; bit positions are software visible
    typedef struct packed {
        logic [PRE_W-1:0] pre;      // 15:8 prescale value
        logic [1:0]       spare_hi; // 7:6
        logic             run;      // 5
        logic [SEL_W-1:0] div_sel;  // 4:3
        logic             irq_en;   // 2
        logic             spare_lo; // 1
        logic             rst_en;   // 0
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_RELD,
        SEL_CNT,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL: return SEL_CTRL;
            OFS_RELD: return SEL_RELD;
            OFS_CNT:  return SEL_CNT;
            default:  return SEL_NONE;
        endcase
    endfunction

    // terminal value of the post-prescale divider: 2^(sel+4)-1
    function automatic logic [DIV_W-1:0] div_last(input logic [SEL_W-1:0] s);
        return {DIV_W{1'b1}} >> (SEL_MAX - int'(s));
    endfunction

endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  cnt,
    output ctrl_t             ctrl,
    output logic [REG_W-1:0]  reld,
    output logic              wr_ctrl,
    output logic              wr_cnt,
    output logic [REG_W-1:0]  rdata
);
    reg_sel_e sel;

    always_comb begin
        sel     = decode_ofs(addr);
        wr_ctrl = wr_en && (sel == SEL_CTRL);
        wr_cnt  = wr_en && (sel == SEL_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= ctrl_t'(CTRL_INIT);
            reld <= RELD_INIT;
        end else if (wr_en) begin
            if (sel == SEL_CTRL) ctrl <= ctrl_t'(wdata);
            if (sel == SEL_RELD) reld <= wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = REG_W'(ctrl);
            SEL_RELD: rdata = reld;
            SEL_CNT:  rdata = cnt;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_prescale.sv
`timescale 1ns/1ps
module wdt_prescale
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic             pre_wrap;
    logic [DIV_W-1:0] last;

    always_comb begin
        last     = div_last(div_sel);
        pre_wrap = (pre_q == pre);
        tick     = run && pre_wrap && (div_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (run) begin
            if (pre_wrap) begin
                pre_q <= '0;
                div_q <= (div_q == last) ? '0 : div_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic             tick,
    input  logic [REG_W-1:0] reld,
    input  logic             rst_en,
    input  logic             irq_en,
    output logic [REG_W-1:0] cnt,
    output logic             irq,
    output logic             reset_req
);
    logic expire;

    always_comb expire = tick && (cnt <= REG_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= CNT_INIT;
            irq       <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load) begin
                cnt <= load_val;
            end else if (expire) begin
                if (rst_en) begin
                    reset_req <= 1'b1;
                    cnt       <= '0;
                end else begin
                    cnt <= reld;
                    irq <= irq_en;
                end
            end else if (tick) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_timer.sv
`timescale 1ns/1ps
module wdt_timer
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq,
    output logic              reset_req
);
    ctrl_t            ctrl_q;
    logic [REG_W-1:0] reld_q;
    logic [REG_W-1:0] cnt_q;
    logic             wr_ctrl;
    logic             wr_cnt;
    logic             tick;
    logic             chain_run;

    // counting freezes once a reset request is pending
    always_comb chain_run = ctrl_q.run && !reset_req;

    wdt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .cnt     (cnt_q),
        .ctrl    (ctrl_q),
        .reld    (reld_q),
        .wr_ctrl (wr_ctrl),
        .wr_cnt  (wr_cnt),
        .rdata   (rdata)
    );

    wdt_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_ctrl || wr_cnt),
        .run     (chain_run),
        .pre     (ctrl_q.pre),
        .div_sel (ctrl_q.div_sel),
        .tick    (tick)
    );

    wdt_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (wr_cnt),
        .load_val  (wdata),
        .tick      (tick),
        .reld      (reld_q),
        .rst_en    (ctrl_q.rst_en),
        .irq_en    (ctrl_q.irq_en),
        .cnt       (cnt_q),
        .irq       (irq),
        .reset_req (reset_req)
    );
endmodule

// File: rtl/wdt_timer_chk.sv
`timescale 1ns/1ps
module wdt_timer_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  ctrl,
    input logic [REG_W-1:0]  reld,
    input logic [REG_W-1:0]  cnt,
    input logic              irq,
    input logic              reset_req
);
    logic cnt_wr;
    always_comb cnt_wr = wr_en && (addr == OFS_CNT);

    assert_req_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> reset_req);

    assert_req_freezes_count_R5: assert property (@(posedge clk) disable iff (rst)
        (reset_req && !cnt_wr) |=> $stable(cnt));

    assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_reloads_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(ctrl[2]) && cnt == $past(reld)));

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[5] && !cnt_wr) |=> $stable(cnt));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (cnt <= $past(cnt) || cnt == $past(reld)));
endmodule

bind wdt_timer wdt_timer_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .ctrl      (ctrl_q),
    .reld      (reld_q),
    .cnt       (cnt_q),
    .irq       (irq),
    .reset_req (reset_req)
);

// File: tb/test_wdt_timer.sv
`timescale 1ns/1ps
module test_wdt_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic        reset_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    wdt_timer i_wdt_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .reset_req(reset_req)
    );

    function automatic int period(input int p, input int s);
        return (p + 1) << (s + 4);
    endfunction

    function automatic logic [15:0] ctrl_word(input int p, input bit run, input int s,
                                              input bit ie, input bit re);
        return 16'((p << 8) | (int'(run) << 5) | (s << 3) | (int'(ie) << 2) | int'(re));
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int p, s, c, d, n;
        bit ie;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        rd(4'h0, v); check("R2 ctrl", v, 16'h8021);
        rd(4'h4, v); check("R2 reload", v, 16'h8000);
        rd(4'h8, v); check("R2 count", v, 16'h8000);
        check("R2 irq", 16'(irq), 16'h0);
        check("R2 reset_req", 16'(reset_req), 16'h0);

        // R1 / R7 decode, unmapped offset, reload write leaves count
        wr(4'h4, 16'h1234);
        rd(4'h4, v); check("R1 reload readback", v, 16'h1234);
        rd(4'h8, v); check("R7 count untouched by reload write", v, 16'h8000);
        wr(4'hC, 16'hFFFF);
        rd(4'hC, v); check("R1 unmapped reads zero", v, 16'h0000);
        rd(4'h0, v); check("R1 ctrl unchanged by unmapped write", v, 16'h8021);
        rd(4'h4, v); check("R1 reload unchanged by unmapped write", v, 16'h1234);

        // R4 disabled counter holds
        wr(4'h0, ctrl_word(0, 0, 0, 0, 0));
        wr(4'h8, 16'd5);
        idle(100);
        rd(4'h8, v); check("R4 hold while disabled", v, 16'd5);

        // R3 directed period with P=1, S=0 -> 32 clocks
        wr(4'h0, ctrl_word(1, 1, 0, 0, 0));
        wr(4'h8, 16'd10);
        idle(95);
        rd(4'h8, v); check("R3 before third decrement", v, 16'd8);
        idle(1);
        rd(4'h8, v); check("R3 third decrement", v, 16'd7);

        // R3 / R6 random programs
        for (int i = 0; i < 6; i++) begin
            p  = $urandom % 3;
            s  = $urandom % 4;
            ie = 1'($urandom % 2);
            c  = 2 + $urandom % 4;
            d  = 1 + $urandom % 5;
            n  = period(p, s);
            wr(4'h0, ctrl_word(p, 1, s, ie, 0));
            wr(4'h4, 16'(d));
            wr(4'h8, 16'(c));
            idle(c * n - 1);
            rd(4'h8, v); check("R3 count one before expiry", v, 16'd1);
            check("R6 no irq before expiry", 16'(irq), 16'h0);
            idle(1);
            check("R6 irq follows enable bit", 16'(irq), 16'(ie));
            rd(4'h8, v); check("R6 reload after expiry", v, 16'(d));
            idle(1);
            check("R6 irq single cycle", 16'(irq), 16'h0);
        end

        // R8 tick on zero count expires and reloads, no wrap
        wr(4'h0, ctrl_word(0, 1, 0, 1, 0));
        wr(4'h4, 16'd3);
        wr(4'h8, 16'd0);
        idle(15);
        rd(4'h8, v); check("R8 zero count waits for tick", v, 16'd0);
        idle(1);
        check("R8 irq on zero expiry", 16'(irq), 16'h1);
        rd(4'h8, v); check("R8 reload not wrap", v, 16'd3);

        // R9 control write restarts the chain
        wr(4'h0, ctrl_word(0, 1, 0, 0, 0));
        wr(4'h8, 16'd4);
        idle(10);
        wr(4'h0, ctrl_word(0, 1, 0, 0, 0));
        idle(15);
        rd(4'h8, v); check("R9 no early decrement", v, 16'd4);
        idle(1);
        rd(4'h8, v); check("R9 decrement one period after write", v, 16'd3);

        // R5 reset request path
        wr(4'h0, ctrl_word(0, 1, 0, 1, 1));
        wr(4'h8, 16'd2);
        idle(31);
        check("R5 no request before expiry", 16'(reset_req), 16'h0);
        idle(1);
        check("R5 request at expiry", 16'(reset_req), 16'h1);
        check("R5 no irq with reset action", 16'(irq), 16'h0);
        idle(50);
        check("R5 request sticky", 16'(reset_req), 16'h1);
        rd(4'h8, v); check("R5 count stopped", v, 16'd0);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        check("R5 request cleared by reset", 16'(reset_req), 16'h0);
        rd(4'h0, v); check("R2 ctrl after second reset", v, 16'h8021);

        finish_run();
    end
endmodule